// File: doc/BRIEF.md
# Memory Control and Write-Protect Register

A byte-wide control register for a 128K x 8 nonvolatile SRAM model. It holds a two-bit protection level and a one-way lock bit for the serial-number bank. Every SRAM write request is compared against the protected top part of the address space, and the block gives a combinational allow flag for each request. A blocked request raises a one-cycle reject pulse on the next cycle.

The register sits at offset 0x00 of a small control space. An eight-byte serial-number bank sits at offsets 0x01 to 0x08 in the same space. Once the lock bit is set, the bank is frozen. The lock bit cannot be cleared by software; only reset clears it. Requests to copy SRAM into the nonvolatile cells pass through whatever the protection level is, because protection guards ordinary writes only.

Top module: `mem_ctrl_wp`

## Requirements
- R1: After reset, the register at offset 0x00 reads 0x00, lock_o is 0, all eight serial bytes read 0x00, and writes are allowed everywhere.
- R2: A read of offset 0x00 returns the lock bit in bit 6, level bit 1 in bit 3 and level bit 0 in bit 2. All other bits read 0 whatever value was written to them. A read of an unmapped offset returns 0x00.
- R3: Level 0 protects nothing. Level 1 protects 0x18000 to 0x1FFFF. Level 2 protects 0x10000 to 0x1FFFF. Level 3 protects 0x00000 to 0x1FFFF.
- R4: sram_wr_ok_o is high in the same cycle exactly when sram_wr_i is high and sram_addr_i lies outside the protected region.
- R5: wr_reject_o is high for one cycle, in the cycle after each SRAM write request that falls inside the protected region, and is low otherwise.
- R6: Writing 1 to bit 6 of offset 0x00 sets the lock bit. A later write of 0 to that bit leaves it at 1.
- R7: While unlocked, a write to offset 0x01+k (k from 0 to 7) stores the byte in serial byte k, and a read returns it. While locked, such writes are ignored.
- R8: store_go_o equals store_req_i in the same cycle at every protection level.
- R9: lock_o equals the lock bit. The level bits stay writable after the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control-space write strobe |
| reg_addr_i | input | 8 | Control-space offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| sram_wr_i | input | 1 | SRAM write request |
| sram_addr_i | input | 17 | SRAM write address |
| sram_wr_ok_o | output | 1 | Write allowed |
| wr_reject_o | output | 1 | Pulse after a blocked write |
| store_req_i | input | 1 | Store-to-nonvolatile request |
| store_go_o | output | 1 | Store request forwarded |
| lock_o | output | 1 | Serial-number lock status |

## Verification
The hardest state to reach is a locked bank that still holds nonzero serial bytes, combined with level changes after the lock is set. In that state a missing lock gate or a lock that a zero can clear becomes visible. The stimulus first fills the bank with random bytes while unlocked, then sets the lock. It then mixes random bank writes, register writes that clear bit 6, and random SRAM addresses at every level. Each control access is checked against a bench-side model, and the level boundaries 0x0FFFF/0x10000 and 0x17FFF/0x18000 are driven directly.

// File: rtl/mem_ctrl_wp_pkg.sv
package mem_ctrl_wp_pkg;
  localparam int unsigned LOCK_BIT = 6;
  localparam int unsigned LVL_HI   = 3;
  localparam int unsigned LVL_LO   = 2;
  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;
endpackage

// File: rtl/mem_ctrl_wp_region.sv
module mem_ctrl_wp_region
  import mem_ctrl_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  prot_lvl_e          lvl_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o
);
  logic [1:0] top2;
  assign top2 = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    unique case (lvl_i)
      LVL_NONE:    hit_o = 1'b0;
      LVL_QUARTER: hit_o = (top2 == 2'b11);
      LVL_HALF:    hit_o = top2[1];
      default:     hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mem_ctrl_wp_ctrl.sv
module mem_ctrl_wp_ctrl
  import mem_ctrl_wp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output prot_lvl_e  lvl_o,
  output logic       lock_o,
  output logic [7:0] rdata_o
);
  prot_lvl_e lvl_q;
  logic      lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_NONE;
      lock_q <= 1'b0;
    end else if (we_i) begin
      lvl_q  <= prot_lvl_e'({wdata_i[LVL_HI], wdata_i[LVL_LO]});
      lock_q <= lock_q | wdata_i[LOCK_BIT];  // one-way
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[LOCK_BIT] = lock_q;
    rdata_o[LVL_HI]   = lvl_q[1];
    rdata_o[LVL_LO]   = lvl_q[0];
  end

  assign lvl_o  = lvl_q;
  assign lock_o = lock_q;

  a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  a_r9_lvl_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (lvl_q == {$past(wdata_i[LVL_HI]), $past(wdata_i[LVL_LO])}));
endmodule

// File: rtl/mem_ctrl_wp_serial.sv
module mem_ctrl_wp_serial #(
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] sn_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       sn_q[g] <= '0;
      else if (we_i && !lock_i && idx_i == IDX_W'(g))    sn_q[g] <= wdata_i;
    end
    a_r7_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i |=> $stable(sn_q[g]));
  end

  assign rdata_o = sn_q[idx_i];
endmodule

// File: rtl/mem_ctrl_wp.sv
module mem_ctrl_wp
  import mem_ctrl_wp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned N_SN    = 8,
  parameter int unsigned SN_BASE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sram_wr_i,
  input  logic [ADDR_W-1:0] sram_addr_i,
  output logic              sram_wr_ok_o,
  output logic              wr_reject_o,
  input  logic              store_req_i,
  output logic              store_go_o,
  output logic              lock_o
);
  localparam int unsigned SN_IDX_W = (N_SN > 1) ? $clog2(N_SN) : 1;
  localparam int unsigned SN_LAST  = SN_BASE + N_SN - 1;

  prot_lvl_e     lvl;
  logic          lock;
  logic          hit;
  logic          ctrl_sel, sn_sel;
  logic [7:0]    ctrl_rdata, sn_rdata, sn_off;
  logic          reject_q;

  assign ctrl_sel = (reg_addr_i == 8'h00);
  assign sn_sel   = (32'(reg_addr_i) >= SN_BASE) && (32'(reg_addr_i) <= SN_LAST);
  assign sn_off   = reg_addr_i - 8'(SN_BASE);

  mem_ctrl_wp_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i    (reg_wr_i && ctrl_sel),
    .wdata_i (reg_wdata_i),
    .lvl_o   (lvl),
    .lock_o  (lock),
    .rdata_o (ctrl_rdata)
  );

  mem_ctrl_wp_serial #(.N_BYTES(N_SN)) u_serial (
    .clk_i, .rst_ni,
    .we_i    (reg_wr_i && sn_sel),
    .lock_i  (lock),
    .idx_i   (sn_off[SN_IDX_W-1:0]),
    .wdata_i (reg_wdata_i),
    .rdata_o (sn_rdata)
  );

  mem_ctrl_wp_region #(.ADDR_W(ADDR_W)) u_region (
    .lvl_i  (lvl),
    .addr_i (sram_addr_i),
    .hit_o  (hit)
  );

  always_comb begin
    if (ctrl_sel)    reg_rdata_o = ctrl_rdata;
    else if (sn_sel) reg_rdata_o = sn_rdata;
    else             reg_rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_q <= 1'b0;
    else         reject_q <= sram_wr_i && hit;
  end

  assign sram_wr_ok_o = sram_wr_i && !hit;
  assign wr_reject_o  = reject_q;
  assign store_go_o   = store_req_i;  // protection never gates a store
  assign lock_o       = lock;

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_sel |-> ((reg_rdata_o & 8'hB3) == 8'h00));
  a_r3_all_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[3:2] == 2'b11 && ctrl_sel) |-> !sram_wr_ok_o);
  a_r5_reject_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reject_o |-> $past(sram_wr_i && !sram_wr_ok_o));
  a_r4_no_ok_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_wr_i |-> !sram_wr_ok_o);
endmodule

// File: tb/mem_ctrl_wp_bench.sv
module mem_ctrl_wp_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, sram_wr = 0, store_req = 0;
  logic [7:0]  reg_addr = 0, reg_wdata = 0;
  logic [16:0] sram_addr = 0;
  logic [7:0]  reg_rdata;
  logic        ok, rej, go, lock;
  int          total = 0, bad = 0;
  logic [1:0]  m_lvl = 0;
  logic        m_lock = 0;
  logic [7:0]  m_sn [8];

  always #4 clk = ~clk;

  mem_ctrl_wp u_mem_ctrl_wp (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sram_wr_i(sram_wr),
    .sram_addr_i(sram_addr), .sram_wr_ok_o(ok), .wr_reject_o(rej),
    .store_req_i(store_req), .store_go_o(go), .lock_o(lock));

  function automatic logic prot(input logic [1:0] l, input logic [16:0] a);
    case (l)
      2'd0: return 1'b0;
      2'd1: return a >= 17'h18000;
      2'd2: return a >= 17'h10000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 0) return {1'b0, m_lock, 2'b0, m_lvl, 2'b0};
    if (a >= 1 && a <= 8) return m_sn[a-1];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) begin m_lvl = {d[3], d[2]}; m_lock = m_lock | d[6]; end
    else if (a >= 1 && a <= 8 && !m_lock) m_sn[a-1] = d;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    @(negedge clk);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp_rd(a));
  endtask

  task automatic sram(input logic [16:0] a, input logic st);
    @(negedge clk);
    sram_wr = 1; sram_addr = a; store_req = st; #1;
    chk("R4", ok, !prot(m_lvl, a));
    chk("R8", go, st);
    @(negedge clk);
    sram_wr = 0; store_req = 0; #1;
    chk("R5", rej, prot(m_lvl, a));
    @(negedge clk);
    chk("R5 pulse", rej, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    for (int i = 0; i < 8; i++) m_sn[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 10; a++) rd("R1", 8'(a));
    @(negedge clk); chk("R1 lock", lock, 0);
    sram(17'h1FFFF, 0);
    // R2 reserved bits ignored
    wr(8'h00, 8'hB3); rd("R2", 8'h00);
    wr(8'h00, 8'h00); rd("R2", 8'h00);
    rd("R2 unmapped", 8'h09); rd("R2 unmapped", 8'hFF);
    // R3 boundaries at each level
    for (int l = 0; l < 4; l++) begin
      wr(8'h00, 8'(l << 2)); rd("R3 lvl", 8'h00);
      sram(17'h00000, 1); sram(17'h0FFFF, 0); sram(17'h10000, 1);
      sram(17'h17FFF, 0); sram(17'h18000, 0); sram(17'h1FFFF, 1);
    end
    // R7 unlocked fill
    wr(8'h00, 8'h00);
    for (int k = 0; k < 8; k++) wr(8'(k + 1), 8'($urandom));
    for (int k = 0; k < 8; k++) rd("R7 unlocked", 8'(k + 1));
    // R6 set lock
    wr(8'h00, 8'h40); rd("R6 set", 8'h00);
    @(negedge clk); chk("R9 lock_o", lock, 1);
    wr(8'h00, 8'h00); rd("R6 sticky", 8'h00);
    @(negedge clk); chk("R9 lock_o sticky", lock, 1);
    // random mix while locked
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 3)
        0: wr(8'h00, 8'($urandom));
        1: wr(8'(1 + $urandom % 8), 8'($urandom));
        default: sram(17'($urandom), 1'($urandom));
      endcase
      rd("R7 R9 mix", 8'($urandom % 10));
      @(negedge clk); chk("R6 lock_o", lock, 1);
    end
    for (int k = 0; k < 8; k++) rd("R7 locked", 8'(k + 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule